// File: doc/BRIEF.md
# Mode-Selectable Direct-Mapped Data Cache Controller

This block is a small direct-mapped data cache. It sits between a processor load/store port and a memory port that moves one word per handshake. Every access carries a bit that picks copyback or write-through handling for its region. Each line holds a valid flag and a modified flag, so a line is invalid, clean or modified.

Allocation depends on the kind of access and its mode. A replaced line that is modified is first copied into a one-line push buffer. The new line is then filled from memory and the processor gets its answer. Only after that is the push buffer written back to memory. Two maintenance commands are provided. One clears every valid flag at once. The other pushes or drops a single line chosen by index.

The processor holds its request until the block answers with a one-cycle ready pulse. The block takes one access at a time and does not accept another until any pending write-back has finished.

Top module: `dcache_ctl`

## Requirements
- R1: Line state is two flags: V=0 means invalid, V=1/M=0 means clean and V=1/M=1 means modified. M is never set without V. After reset every line is invalid, so the first access to any address misses.
- R2: A load miss to a line that is not modified reads all four words of the new line. The reads are at consecutive addresses with word offset 0 first, and the line becomes valid. The requested word is returned.
- R3: A load hit returns the cached word, makes no memory access and leaves the line state unchanged.
- R4: A copyback store miss fills the line from memory and merges the store word into it. The line becomes modified and memory is not written.
- R5: A write-through store miss makes exactly one memory write at the store address and allocates nothing. A later load of that line still misses.
- R6: A copyback store hit updates only the cache and makes the line modified. It makes no memory access.
- R7: A write-through store hit to a clean line writes the word to both memory and cache, and the line stays clean. Replacing it later writes nothing back.
- R8: A load miss on a modified line copies the victim to the push buffer and then fills the new line. The ready pulse comes with no victim word yet written. After the pulse, the four victim words are written in ascending order, and the new line ends clean.
- R9: A copyback store miss on a modified line follows the same order (victim saved, fill, merge, ready, write-back), and the new line ends modified.
- R10: A store in write-through mode that hits a modified line writes the word to memory and to the cache, and the line stays modified. A later push still writes the whole line back.
- R11: Invalidate-all (op code 2) clears V on every line in one step and writes nothing to memory. Modified contents are discarded.
- R12: Line push (op code 3) selects the line by address bits [5:2]. A modified line is written back as four words and made invalid. With the inhibit bit set, the line is made invalid and nothing is written.
- R13: Op codes are 0 load and 1 store; cpu_wt=1 selects write-through. cpu_ready is a one-cycle pulse per accepted request. mem_req, mem_addr and mem_we hold steady until mem_ready completes the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_op | input | 2 | 0 load, 1 store, 2 invalidate-all, 3 line push |
| cpu_wt | input | 1 | 1 = write-through region, 0 = copyback |
| cpu_inhibit | input | 1 | Line push drops data without write-back |
| cpu_addr | input | ADDR_W | Word address (tag, index, word offset) |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Completes the current word |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
A wrong tag or valid flag shows up on the very next access to that index. It appears either as unexpected memory reads on what should be a hit, or as a missing fill that returns stale data. A lost or spurious modified flag stays hidden until the line is replaced or pushed. At that point it becomes missing or extra write-back traffic, and the final memory image differs from a flat reference memory. For that reason, every scenario ends by forcing the line out and counting the memory transactions, and a mixed run is closed by pushing every line and comparing the whole memory.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

   typedef enum logic [1:0] {
      OP_LOAD    = 2'd0,
      OP_STORE   = 2'd1,
      OP_INV_ALL = 2'd2,
      OP_PUSH    = 2'd3
   } cache_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_FILL,
      ST_WTHRU,
      ST_RESP,
      ST_DRAIN
   } ctl_state_e;

   typedef struct packed {
      logic valid;
      logic dirty;
   } line_state_t;

endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store
   import dcache_pkg::*;
#(
   parameter int IDX_W = 4,
   parameter int TAG_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [TAG_W-1:0]  rd_tag,
   output line_state_t       rd_st,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  line_state_t       wr_st,
   input  logic              clr_all
);
   localparam int LINES = 1 << IDX_W;

   logic [TAG_W-1:0] tag_q [LINES];
   logic             v_q   [LINES];
   logic             m_q   [LINES];

   if (IDX_W < 1) begin : g_chk_idx
      $error("dcache_tag_store: IDX_W must be at least 1");
   end

   for (genvar i = 0; i < LINES; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q[i] <= 1'b0;
            m_q[i] <= 1'b0;
         end else if (clr_all) begin
            v_q[i] <= 1'b0;
            m_q[i] <= 1'b0;
         end else if (wr_en && wr_idx == IDX_W'(i)) begin
            v_q[i] <= wr_st.valid;
            m_q[i] <= wr_st.dirty;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_en && wr_idx == IDX_W'(i)) tag_q[i] <= wr_tag;
      end

      AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
         m_q[i] |-> v_q[i]); // R1
   end

   assign rd_tag      = tag_q[rd_idx];
   assign rd_st.valid = v_q[rd_idx];
   assign rd_st.dirty = m_q[rd_idx];

endmodule

// File: rtl/dcache_data_store.sv
module dcache_data_store #(
   parameter int IDX_W  = 4,
   parameter int OFF_W  = 2,
   parameter int DATA_W = 32
) (
   input  logic                           clk,
   input  logic [IDX_W-1:0]               rd_idx,
   input  logic [OFF_W-1:0]               rd_off,
   output logic [DATA_W-1:0]              rd_word,
   output logic [(DATA_W<<OFF_W)-1:0]     rd_line,
   input  logic                           wr_en,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [OFF_W-1:0]               wr_off,
   input  logic [DATA_W-1:0]              wr_data
);
   localparam int LINES = 1 << IDX_W;
   localparam int WORDS = 1 << OFF_W;

   logic [DATA_W-1:0] arr_q [LINES][WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) arr_q[wr_idx][wr_off] <= wr_data;
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      assign rd_line[w*DATA_W +: DATA_W] = arr_q[rd_idx][w];
   end

   assign rd_word = arr_q[rd_idx][rd_off];

endmodule

// File: rtl/dcache_push_buf.sv
module dcache_push_buf #(
   parameter int OFF_W   = 2,
   parameter int DATA_W  = 32,
   parameter int LADDR_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  logic [(DATA_W<<OFF_W)-1:0] load_line,
   input  logic [LADDR_W-1:0]         load_base,
   input  logic                       drained,
   input  logic [OFF_W-1:0]           sel,
   output logic [DATA_W-1:0]          word,
   output logic [LADDR_W-1:0]         base,
   output logic                       full
);
   localparam int WORDS = 1 << OFF_W;

   logic [DATA_W-1:0] hold_q [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       full <= 1'b0;
      else if (load)    full <= 1'b1;
      else if (drained) full <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (load) base <= load_base;
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_hold
      always_ff @(posedge clk) begin
         if (load) hold_q[w] <= load_line[w*DATA_W +: DATA_W];
      end
   end

   assign word = hold_q[sel];

   AST_PUSH_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !full); // R8

endmodule

// File: rtl/dcache_ctl.sv
module dcache_ctl
   import dcache_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4,
   parameter int OFF_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic [1:0]        cpu_op,
   input  logic              cpu_wt,
   input  logic              cpu_inhibit,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int WORDS   = 1 << OFF_W;
   localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
   localparam int LADDR_W = ADDR_W - OFF_W;
   localparam int LINE_W  = WORDS * DATA_W;
   localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS - 1);

   if (TAG_W < 1) begin : g_chk_tag
      $error("dcache_ctl: ADDR_W leaves no tag bits");
   end
   if (OFF_W < 1) begin : g_chk_off
      $error("dcache_ctl: a line needs at least two words");
   end

   ctl_state_e         st, st_d;
   cache_op_e          q_op;
   logic               q_wt, q_inh;
   logic [ADDR_W-1:0]  q_addr;
   logic [DATA_W-1:0]  q_wdata;
   logic [OFF_W-1:0]   cnt;
   logic               cnt_clr, cnt_inc;
   logic [DATA_W-1:0]  rdata_q;
   logic               grab_word, grab_mem;

   logic [TAG_W-1:0]   a_tag;
   logic [IDX_W-1:0]   a_idx;
   logic [OFF_W-1:0]   a_off;

   logic [TAG_W-1:0]   rd_tag;
   line_state_t        rd_st;
   logic               hit, victim_dirty;

   logic               tw_en, clr_all;
   logic [TAG_W-1:0]   tw_tag;
   line_state_t        tw_st;

   logic               dw_en;
   logic [OFF_W-1:0]   dw_off;
   logic [DATA_W-1:0]  dw_data;
   logic [DATA_W-1:0]  rd_word;
   logic [LINE_W-1:0]  rd_line;

   logic               pb_load, pb_done, pb_full;
   logic [DATA_W-1:0]  pb_word;
   logic [LADDR_W-1:0] pb_base;

   assign {a_tag, a_idx, a_off} = q_addr;
   assign hit          = rd_st.valid && (rd_tag == a_tag);
   assign victim_dirty = rd_st.valid && rd_st.dirty;

   dcache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (a_idx),
      .rd_tag  (rd_tag),
      .rd_st   (rd_st),
      .wr_en   (tw_en),
      .wr_idx  (a_idx),
      .wr_tag  (tw_tag),
      .wr_st   (tw_st),
      .clr_all (clr_all)
   );

   dcache_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
      .clk     (clk),
      .rd_idx  (a_idx),
      .rd_off  (a_off),
      .rd_word (rd_word),
      .rd_line (rd_line),
      .wr_en   (dw_en),
      .wr_idx  (a_idx),
      .wr_off  (dw_off),
      .wr_data (dw_data)
   );

   dcache_push_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W), .LADDR_W(LADDR_W)) u_push (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (pb_load),
      .load_line (rd_line),
      .load_base ({rd_tag, a_idx}),
      .drained   (pb_done),
      .sel       (cnt),
      .word      (pb_word),
      .base      (pb_base),
      .full      (pb_full)
   );

   always_comb begin
      st_d      = st;
      tw_en     = 1'b0;
      tw_tag    = a_tag;
      tw_st     = '0;
      clr_all   = 1'b0;
      dw_en     = 1'b0;
      dw_off    = a_off;
      dw_data   = q_wdata;
      pb_load   = 1'b0;
      pb_done   = 1'b0;
      cnt_clr   = 1'b0;
      cnt_inc   = 1'b0;
      grab_word = 1'b0;
      grab_mem  = 1'b0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = q_addr;
      mem_wdata = q_wdata;
      unique case (st)
         ST_IDLE: if (cpu_req) st_d = ST_LOOK;
         ST_LOOK: begin
            cnt_clr = 1'b1;
            unique case (q_op)
               OP_INV_ALL: begin
                  clr_all = 1'b1;
                  st_d    = ST_RESP;
               end
               OP_PUSH: begin
                  tw_en   = 1'b1;
                  tw_tag  = rd_tag;
                  pb_load = victim_dirty && !q_inh;
                  st_d    = ST_RESP;
               end
               OP_LOAD: begin
                  if (hit) begin
                     grab_word = 1'b1;
                     st_d      = ST_RESP;
                  end else begin
                     pb_load = victim_dirty;
                     st_d    = ST_FILL;
                  end
               end
               OP_STORE: begin
                  if (hit) begin
                     dw_en = 1'b1;
                     if (q_wt) begin
                        st_d = ST_WTHRU;
                     end else begin
                        tw_en = 1'b1;
                        tw_st = '{valid: 1'b1, dirty: 1'b1};
                        st_d  = ST_RESP;
                     end
                  end else if (q_wt) begin
                     st_d = ST_WTHRU;
                  end else begin
                     pb_load = victim_dirty;
                     st_d    = ST_FILL;
                  end
               end
            endcase
         end
         ST_FILL: begin
            mem_req  = 1'b1;
            mem_addr = {a_tag, a_idx, cnt};
            if (mem_ready) begin
               dw_en    = 1'b1;
               dw_off   = cnt;
               dw_data  = (q_op == OP_STORE && cnt == a_off) ? q_wdata : mem_rdata;
               grab_mem = (cnt == a_off);
               cnt_inc  = 1'b1;
               if (cnt == LAST) begin
                  tw_en = 1'b1;
                  tw_st = '{valid: 1'b1, dirty: (q_op == OP_STORE)};
                  st_d  = ST_RESP;
               end
            end
         end
         ST_WTHRU: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
            if (mem_ready) st_d = ST_RESP;
         end
         ST_RESP: begin
            cnt_clr = 1'b1;
            st_d    = pb_full ? ST_DRAIN : ST_IDLE;
         end
         ST_DRAIN: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {pb_base, cnt};
            mem_wdata = pb_word;
            if (mem_ready) begin
               cnt_inc = 1'b1;
               if (cnt == LAST) begin
                  pb_done = 1'b1;
                  st_d    = ST_IDLE;
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         st <= st_d;
         if (cnt_clr)      cnt <= '0;
         else if (cnt_inc) cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (st == ST_IDLE && cpu_req) begin
         q_op    <= cache_op_e'(cpu_op);
         q_wt    <= cpu_wt;
         q_inh   <= cpu_inhibit;
         q_addr  <= cpu_addr;
         q_wdata <= cpu_wdata;
      end
      if (grab_word)     rdata_q <= rd_word;
      else if (grab_mem) rdata_q <= mem_rdata;
   end

   assign cpu_ready = (st == ST_RESP);
   assign cpu_rdata = rdata_q;

   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready); // R13
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R13
   AST_DRAIN_AFTER_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == ST_DRAIN) |-> $past(cpu_ready)); // R8

endmodule

// File: tb/tb_dcache_ctl.sv
`timescale 1ns/1ps
module tb_dcache_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic [1:0]  cpu_op = 2'd0;
   logic        cpu_wt = 1'b0;
   logic        cpu_inhibit = 1'b0;
   logic [9:0]  cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_ready;
   logic [31:0] cpu_rdata;
   logic        mem_req, mem_we;
   logic [9:0]  mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ready;
   logic [31:0] mem_rdata;

   always #4 clk = ~clk;

   dcache_ctl dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_wt(cpu_wt),
      .cpu_inhibit(cpu_inhibit), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
   );

   // backing memory with one wait cycle per word, plus a transaction log
   logic [31:0] mem [1024];
   logic [31:0] ref_mem [1024];
   int          rd_total, wr_total;
   logic [9:0]  rd_log [64];
   logic [9:0]  wr_log [64];
   logic [31:0] wd_log [64];

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ready <= 1'b0;
         rd_total  <= 0;
         wr_total  <= 0;
         for (int i = 0; i < 1024; i++) mem[i] <= 32'hA000_0000 + i;
      end else if (mem_req && mem_ready) begin
         mem_ready <= 1'b0;
         if (mem_we) begin
            mem[mem_addr]         <= mem_wdata;
            wr_log[wr_total % 64] <= mem_addr;
            wd_log[wr_total % 64] <= mem_wdata;
            wr_total              <= wr_total + 1;
         end else begin
            rd_log[rd_total % 64] <= mem_addr;
            rd_total              <= rd_total + 1;
         end
      end else if (mem_req) begin
         mem_ready <= 1'b1;
         mem_rdata <= mem[mem_addr];
      end
   end

   int          n_chk = 0, n_fail = 0;
   int          base_rd, base_wr, rdy_rd, rdy_wr, fin_rd, fin_wr;
   logic [31:0] last_rd;
   logic        ready_after;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input logic [1:0] op, input logic [9:0] a, input logic [31:0] d,
                         input bit wt, input bit inh);
      @(negedge clk);
      base_rd = rd_total; base_wr = wr_total;
      cpu_op = op; cpu_addr = a; cpu_wdata = d; cpu_wt = wt; cpu_inhibit = inh;
      cpu_req = 1'b1;
      do @(negedge clk); while (!cpu_ready);
      last_rd = cpu_rdata;
      rdy_rd = rd_total - base_rd; rdy_wr = wr_total - base_wr;
      cpu_req = 1'b0;
      @(negedge clk);
      ready_after = cpu_ready;
      repeat (14) @(negedge clk);
      fin_rd = rd_total - base_rd; fin_wr = wr_total - base_wr;
   endtask

   task automatic ld(input logic [9:0] a);                   access(2'd0, a, 32'h0, 1'b0, 1'b0); endtask
   task automatic sto(input logic [9:0] a, input logic [31:0] d, input bit wt); access(2'd1, a, d, wt, 1'b0); endtask
   task automatic inv_all();                                access(2'd2, 10'h0, 32'h0, 1'b0, 1'b0); endtask
   task automatic push(input logic [3:0] idx, input bit inh); access(2'd3, {4'h0, idx, 2'b00}, 32'h0, 1'b0, inh); endtask

   task automatic t_reset();
      chk(cpu_ready == 1'b0, "R13 ready low after reset", 32'(cpu_ready), 32'h0);
      chk(mem_req == 1'b0, "R13 no memory request after reset", 32'(mem_req), 32'h0);
   endtask

   task automatic t_read_miss();
      ld(10'h012);
      chk(fin_rd == 4 && fin_wr == 0, "R1 first access misses after reset", 32'(fin_rd), 32'h4);
      chk(last_rd == 32'hA000_0012, "R2 miss data", last_rd, 32'hA000_0012);
      for (int k = 0; k < 4; k++)
         chk(rd_log[(base_rd + k) % 64] == 10'h010 + k, "R2 ascending fill order",
             32'(rd_log[(base_rd + k) % 64]), 32'h010 + k);
      chk(ready_after == 1'b0, "R13 ready is one cycle", 32'(ready_after), 32'h0);
      ld(10'h011);
      chk(fin_rd == 0 && fin_wr == 0, "R3 hit makes no memory access", 32'(fin_rd + fin_wr), 32'h0);
      chk(last_rd == 32'hA000_0011, "R3 hit data", last_rd, 32'hA000_0011);
   endtask

   task automatic t_cb_write_miss();
      sto(10'h025, 32'hDEAD_0001, 1'b0);
      chk(fin_rd == 4 && fin_wr == 0, "R4 copyback store miss fills only", 32'(fin_rd), 32'h4);
      chk(mem[10'h025] == 32'hA000_0025, "R4 memory untouched", mem[10'h025], 32'hA000_0025);
      ld(10'h025);
      chk(fin_rd == 0 && last_rd == 32'hDEAD_0001, "R4 merged word hits", last_rd, 32'hDEAD_0001);
      ld(10'h024);
      chk(fin_rd == 0 && last_rd == 32'hA000_0024, "R4 neighbour word from fill", last_rd, 32'hA000_0024);
   endtask

   task automatic t_wt_write_miss();
      sto(10'h031, 32'h1111_0031, 1'b1);
      chk(fin_wr == 1 && fin_rd == 0 && wr_log[base_wr % 64] == 10'h031,
          "R5 single memory write", 32'(fin_wr), 32'h1);
      ld(10'h031);
      chk(fin_rd == 4, "R5 no allocation, load misses", 32'(fin_rd), 32'h4);
      chk(last_rd == 32'h1111_0031, "R5 data reached memory", last_rd, 32'h1111_0031);
   endtask

   task automatic t_cb_write_hit();
      sto(10'h013, 32'h2222_0013, 1'b0);
      chk(fin_rd == 0 && fin_wr == 0, "R6 copyback hit no memory access", 32'(fin_rd + fin_wr), 32'h0);
      ld(10'h013);
      chk(last_rd == 32'h2222_0013, "R6 cache updated", last_rd, 32'h2222_0013);
   endtask

   task automatic t_read_miss_modified();
      ld(10'h113);
      chk(rdy_rd == 4 && rdy_wr == 0, "R8 fill done, nothing written at ready", 32'(rdy_wr), 32'h0);
      chk(last_rd == 32'hA000_0113, "R8 new line data", last_rd, 32'hA000_0113);
      chk(fin_wr == 4, "R8 victim drained after reply", 32'(fin_wr), 32'h4);
      for (int k = 0; k < 4; k++)
         chk(wr_log[(base_wr + k) % 64] == 10'h010 + k, "R8 drain order",
             32'(wr_log[(base_wr + k) % 64]), 32'h010 + k);
      chk(mem[10'h013] == 32'h2222_0013, "R8 victim data written", mem[10'h013], 32'h2222_0013);
      ld(10'h110);
      chk(fin_rd == 0 && last_rd == 32'hA000_0110, "R8 new line hits", last_rd, 32'hA000_0110);
      ld(10'h210);
      chk(fin_wr == 0, "R8 new line ended clean", 32'(fin_wr), 32'h0);
   endtask

   task automatic t_write_miss_modified();
      sto(10'h014, 32'h3333_0014, 1'b0);
      sto(10'h116, 32'h4444_0116, 1'b0);
      chk(rdy_rd == 4 && rdy_wr == 0, "R9 fill before drain", 32'(rdy_wr), 32'h0);
      chk(fin_wr == 4 && wd_log[base_wr % 64] == 32'h3333_0014, "R9 victim drained",
          wd_log[base_wr % 64], 32'h3333_0014);
      ld(10'h116);
      chk(fin_rd == 0 && last_rd == 32'h4444_0116, "R9 merged word", last_rd, 32'h4444_0116);
      push(4'd5, 1'b0);
      chk(fin_wr == 4 && mem[10'h116] == 32'h4444_0116, "R9 line ended modified", mem[10'h116], 32'h4444_0116);
   endtask

   task automatic t_wt_hit_modified();
      sto(10'h018, 32'h5555_0018, 1'b0);
      sto(10'h019, 32'h6666_0019, 1'b1);
      chk(fin_wr == 1 && fin_rd == 0 && mem[10'h019] == 32'h6666_0019, "R10 memory written",
          mem[10'h019], 32'h6666_0019);
      ld(10'h019);
      chk(fin_rd == 0 && last_rd == 32'h6666_0019, "R10 cache written", last_rd, 32'h6666_0019);
      push(4'd6, 1'b0);
      chk(fin_wr == 4 && mem[10'h018] == 32'h5555_0018, "R10 line stayed modified", mem[10'h018], 32'h5555_0018);
   endtask

   task automatic t_wt_hit_clean();
      ld(10'h01C);
      sto(10'h01D, 32'h7777_001D, 1'b1);
      chk(fin_wr == 1 && mem[10'h01D] == 32'h7777_001D, "R7 write-through hit writes memory",
          mem[10'h01D], 32'h7777_001D);
      ld(10'h01D);
      chk(fin_rd == 0 && last_rd == 32'h7777_001D, "R7 cache updated", last_rd, 32'h7777_001D);
      ld(10'h11C);
      chk(fin_rd == 4 && fin_wr == 0, "R7 line stayed clean", 32'(fin_wr), 32'h0);
   endtask

   task automatic t_push_inhibit();
      sto(10'h020, 32'h8888_0020, 1'b0);
      push(4'd8, 1'b1);
      chk(fin_wr == 0, "R12 inhibit writes nothing", 32'(fin_wr), 32'h0);
      ld(10'h020);
      chk(fin_rd == 4 && last_rd == 32'hA000_0020, "R12 line invalid, data dropped", last_rd, 32'hA000_0020);
   endtask

   task automatic t_inv_all();
      sto(10'h028, 32'h9999_0028, 1'b0);
      inv_all();
      chk(fin_wr == 0 && fin_rd == 0, "R11 no memory traffic", 32'(fin_wr + fin_rd), 32'h0);
      ld(10'h028);
      chk(fin_rd == 4 && last_rd == 32'hA000_0028, "R11 modified data discarded", last_rd, 32'hA000_0028);
      ld(10'h025);
      chk(fin_rd == 4 && last_rd == 32'hA000_0025, "R11 all lines invalid", last_rd, 32'hA000_0025);
   endtask

   task automatic t_mixed();
      int unsigned seed = 32'h1234_5678;
      int          bad = 0;
      inv_all();
      for (int i = 0; i < 1024; i++) ref_mem[i] = mem[i];
      for (int n = 0; n < 300; n++) begin
         logic [9:0] a;
         seed = seed * 32'd1664525 + 32'd1013904223;
         a = {2'b00, seed[23:16]};
         if (seed[30]) begin
            sto(a, seed ^ 32'h5A5A_0000, seed[29]);
            ref_mem[a] = seed ^ 32'h5A5A_0000;
         end else begin
            ld(a);
            chk(last_rd == ref_mem[a], "R3 mixed load vs reference", last_rd, ref_mem[a]);
         end
      end
      for (int x = 0; x < 16; x++) push(4'(x), 1'b0);
      for (int i = 0; i < 1024; i++) if (mem[i] != ref_mem[i]) bad++;
      chk(bad == 0, "R12 flushed memory matches reference", 32'(bad), 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read_miss();
      t_cb_write_miss();
      t_wt_write_miss();
      t_cb_write_hit();
      t_read_miss_modified();
      t_write_miss_modified();
      t_wt_hit_modified();
      t_wt_hit_clean();
      t_push_inhibit();
      t_inv_all();
      t_mixed();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R13 watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule